// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block shares one parallel bus among four requesters. Requester 0 is the local host controller and requesters 1 to 3 are three external masters. Each requester has a request bit in `req_i` and a grant bit in `gnt_o` at the same position. A per-requester bit in `prio_hi_i` places it in the high group (1) or the low group (0). A round robin runs inside each group. The low group as a whole fills one extra slot of the high-group rotation, and that slot sits after requester 3 and before requester 0.

The grant moves on as soon as the granted master signals the start of its transaction on `frame_start_i`. That master then becomes the last in line within its group. A grant that has not yet been used can move to a requester that comes earlier in the rotation. When the bus is idle and the grant must change hands, one clock with no grant is inserted. With no requests pending, the bus is parked either on the host controller or on the master that used it last.

A disable input turns the internal arbitration off. The host controller's request then goes out on `ext_req_o`, and an external arbiter's grant, taken in on `ext_gnt_i`, reaches the host on `gnt_o[0]`.

Top module: `duo_tier_arbiter`

## Requirements
- R1: Bit k of `req_i`, `prio_hi_i` and `gnt_o` belongs to requester k, where 0 is the host controller and 1 to 3 are the external masters. While `rst` is high, `gnt_o` and `ext_req_o` are 0. After reset, with all four requesting in the high group, the first grant goes to requester 0.
- R2: At most one bit of `gnt_o` is 1 in any cycle.
- R3: Within a group, the next grant goes to the first requesting member after the last member that started a transaction, in ascending index order with wrap-around. Members that are not requesting are skipped.
- R4: The low group holds one slot in the high-group rotation, placed after index 3. With requesters 0 and 1 high, requesters 2 and 3 low, and all four always requesting and starting at once, the grant order is 0,1,2,0,1,3,0,1,2.
- R5: When the granted master pulses `frame_start_i` while the bus is busy (`bus_idle_i`=0) and another requester is pending, `gnt_o` moves to the next winner on the following clock edge.
- R6: A grant that has not been used moves away when a requester placed earlier in the rotation asserts its request.
- R7: If the grant must change hands while `bus_idle_i`=1, `gnt_o` is all zero for one clock, and the new winner is granted on the next clock.
- R8: With no requests, the bus is parked on requester 0 when `park_last_i`=0. When `park_last_i`=1 it is parked on the requester that last started a transaction.
- R9: While `arb_off_i`=1, `gnt_o[3:1]` is 0, `gnt_o[0]` follows `ext_gnt_i`, and `ext_req_o` follows `req_i[0]`. While `arb_off_i`=0, `ext_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Request per requester (bit 0 = host) |
| prio_hi_i | input | 4 | 1 = high group, 0 = low group |
| park_last_i | input | 1 | 1 = park on last user, 0 = park on host |
| arb_off_i | input | 1 | Disable internal arbitration |
| bus_idle_i | input | 1 | Bus currently idle |
| frame_start_i | input | 1 | Granted master starts its transaction |
| ext_gnt_i | input | 1 | Grant from external arbiter when disabled |
| gnt_o | output | 4 | Grant per requester, at most one set |
| ext_req_o | output | 1 | Host request toward external arbiter when disabled |

## Verification
The main function is tried with four input patterns. A sequence in which everyone is high priority walks the single-group rotation and shows whether non-requesters are skipped and whether the transaction starter drops to last place. Two high and two low requesters that all request at once tell apart a correct slot for the low group from a flat four-way rotation, because the grant order differs after the third grant. An idle-bus handover and a late request from the host check the empty clock and the preemption, and runs with the park mode set both ways show the two park targets apart.

// File: rtl/duo_arb_pkg.sv
package duo_arb_pkg;

    localparam int ARB_N  = 4;
    localparam int IDX_W  = $clog2(ARB_N);
    localparam int SLOT_N = ARB_N + 1;
    localparam int SLOT_W = $clog2(SLOT_N);

    typedef logic [ARB_N-1:0]  dev_vec_t;
    typedef logic [IDX_W-1:0]  dev_idx_t;
    typedef logic [SLOT_W-1:0] slot_idx_t;

    // slot index standing for the whole low group in the high rotation
    localparam slot_idx_t LOW_SLOT = slot_idx_t'(ARB_N);

    typedef struct packed {
        logic     valid;
        dev_idx_t idx;
    } owner_t;

    typedef struct packed {
        slot_idx_t hi_ptr;
        dev_idx_t  lo_ptr;
        dev_idx_t  last_user;
    } rot_state_t;

    localparam rot_state_t ROT_RESET = '{
        hi_ptr:    LOW_SLOT,
        lo_ptr:    dev_idx_t'(ARB_N - 1),
        last_user: '0
    };

    function automatic dev_vec_t idx_to_vec(input dev_idx_t i);
        dev_vec_t v;
        v    = '0;
        v[i] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/dar_rr_pick.sv
module dar_rr_pick #(
    parameter int W  = 4,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  cand,
    input  logic [PW-1:0] last,
    output logic          found,
    output logic [PW-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = last;
        // scan downward so the nearest candidate after `last` is kept
        for (int i = W; i >= 1; i--) begin
            int k;
            k = int'(last) + i;
            if (k >= W) k = k - W;
            if (cand[PW'(k)]) begin
                found = 1'b1;
                pick  = PW'(k);
            end
        end
    end
endmodule

// File: rtl/dar_rotation.sv
module dar_rotation
    import duo_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_ev,
    input  dev_idx_t   owner_idx,
    input  logic       owner_hi,
    output rot_state_t eff
);
    rot_state_t st_q;

    // pointers as seen this cycle, including a start happening now
    always_comb begin
        eff = st_q;
        if (start_ev) begin
            eff.last_user = owner_idx;
            if (owner_hi) begin
                eff.hi_ptr = slot_idx_t'(owner_idx);
            end else begin
                eff.hi_ptr = LOW_SLOT;
                eff.lo_ptr = owner_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ROT_RESET;
        else     st_q <= eff;
    end
endmodule

// File: rtl/dar_select.sv
module dar_select
    import duo_arb_pkg::*;
(
    input  dev_vec_t   req,
    input  dev_vec_t   prio_hi,
    input  logic       park_last,
    input  rot_state_t eff,
    output dev_idx_t   target
);
    dev_vec_t          hi_req;
    dev_vec_t          lo_req;
    logic [SLOT_N-1:0] slot_cand;
    logic              hi_found;
    slot_idx_t         hi_slot;
    logic              lo_found;
    dev_idx_t          lo_pick;

    assign hi_req    = req & prio_hi;
    assign lo_req    = req & ~prio_hi;
    assign slot_cand = {|lo_req, hi_req};

    dar_rr_pick #(.W(SLOT_N), .PW(SLOT_W)) u_hi (
        .cand(slot_cand), .last(eff.hi_ptr), .found(hi_found), .pick(hi_slot)
    );

    dar_rr_pick #(.W(ARB_N), .PW(IDX_W)) u_lo (
        .cand(lo_req), .last(eff.lo_ptr), .found(lo_found), .pick(lo_pick)
    );

    always_comb begin
        if (hi_found) begin
            if (hi_slot == LOW_SLOT && lo_found) target = lo_pick;
            else                                 target = hi_slot[IDX_W-1:0];
        end else if (park_last) begin
            target = eff.last_user;
        end else begin
            target = '0;
        end
    end
endmodule

// File: rtl/dar_grant_reg.sv
module dar_grant_reg
    import duo_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     arb_off,
    input  logic     bus_idle,
    input  dev_idx_t target,
    output owner_t   own_q
);
    owner_t own_d;

    always_comb begin
        if (arb_off) begin
            own_d = '0;
        end else if (own_q.valid && own_q.idx == target) begin
            own_d = own_q;
        end else if (own_q.valid && bus_idle) begin
            own_d = '0;                       // turnaround clock
        end else begin
            own_d = '{valid: 1'b1, idx: target};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) own_q <= '0;
        else     own_q <= own_d;
    end
endmodule

// File: rtl/duo_tier_arbiter.sv
module duo_tier_arbiter
    import duo_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] req_i,
    input  logic [3:0] prio_hi_i,
    input  logic       park_last_i,
    input  logic       arb_off_i,
    input  logic       bus_idle_i,
    input  logic       frame_start_i,
    input  logic       ext_gnt_i,
    output logic [3:0] gnt_o,
    output logic       ext_req_o
);
    owner_t     own_q;
    rot_state_t eff;
    dev_idx_t   target;
    logic       start_ev;

    assign start_ev = frame_start_i & own_q.valid & ~arb_off_i;

    dar_rotation u_rot (
        .clk(clk), .rst(rst), .start_ev(start_ev),
        .owner_idx(own_q.idx), .owner_hi(prio_hi_i[own_q.idx]), .eff(eff)
    );

    dar_select u_sel (
        .req(req_i), .prio_hi(prio_hi_i), .park_last(park_last_i),
        .eff(eff), .target(target)
    );

    dar_grant_reg u_gnt (
        .clk(clk), .rst(rst), .arb_off(arb_off_i), .bus_idle(bus_idle_i),
        .target(target), .own_q(own_q)
    );

    always_comb begin
        if (rst) begin
            gnt_o     = '0;
            ext_req_o = 1'b0;
        end else if (arb_off_i) begin
            gnt_o     = {{(ARB_N-1){1'b0}}, ext_gnt_i};
            ext_req_o = req_i[0];
        end else begin
            gnt_o     = own_q.valid ? idx_to_vec(own_q.idx) : '0;
            ext_req_o = 1'b0;
        end
    end
endmodule

// File: rtl/dar_checker.sv
module dar_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] req_i,
    input logic       arb_off_i,
    input logic       bus_idle_i,
    input logic       frame_start_i,
    input logic [3:0] gnt_o
);
    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    // R7
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !arb_off_i && $past(!arb_off_i) && $past(bus_idle_i)
         && $past(gnt_o) != 4'b0 && gnt_o != 4'b0) |-> gnt_o == $past(gnt_o));

    // R8
    park_fill_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !arb_off_i && $past(!arb_off_i)
         && $past(req_i) == 4'b0 && $past(gnt_o) == 4'b0) |-> gnt_o != 4'b0);

    // R5
    grant_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (!arb_off_i && frame_start_i && !bus_idle_i && gnt_o != 4'b0
         && (req_i & ~gnt_o) != 4'b0) |=> (arb_off_i || gnt_o != $past(gnt_o)));

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        arb_off_i |-> gnt_o[3:1] == 3'b0);
endmodule

bind duo_tier_arbiter dar_checker u_chk (
    .clk(clk), .rst(rst), .req_i(req_i), .arb_off_i(arb_off_i),
    .bus_idle_i(bus_idle_i), .frame_start_i(frame_start_i), .gnt_o(gnt_o)
);

// File: tb/duo_tier_arbiter_test.sv
`timescale 1ns/1ps
module duo_tier_arbiter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req_i = '0, prio_hi_i = 4'hF;
    logic       park_last_i = 1'b0, arb_off_i = 1'b0, bus_idle_i = 1'b1;
    logic       frame_start_i = 1'b0, ext_gnt_i = 1'b0;
    logic [3:0] gnt_o;
    logic       ext_req_o;
    int         total = 0, fails = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    duo_tier_arbiter uut (
        .clk(clk), .rst(rst), .req_i(req_i), .prio_hi_i(prio_hi_i),
        .park_last_i(park_last_i), .arb_off_i(arb_off_i), .bus_idle_i(bus_idle_i),
        .frame_start_i(frame_start_i), .ext_gnt_i(ext_gnt_i),
        .gnt_o(gnt_o), .ext_req_o(ext_req_o)
    );

    // row: req, prio, park_last, idle, start, expected grant (all high, park host)
    localparam logic [14:0] VEC [12] = '{
        {4'b0000, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001},  // park host (R8)
        {4'b1110, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0000},  // idle gap (R7)
        {4'b1110, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0010},  // winner after gap (R7)
        {4'b1110, 4'b1111, 1'b0, 1'b0, 1'b1, 4'b0100},  // start moves grant (R5)
        {4'b1110, 4'b1111, 1'b0, 1'b0, 1'b0, 4'b0100},  // hold
        {4'b1010, 4'b1111, 1'b0, 1'b0, 1'b1, 4'b1000},  // skip non-requester (R3)
        {4'b0011, 4'b1111, 1'b0, 1'b0, 1'b1, 4'b0001},  // wrap to host (R3)
        {4'b0000, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001},  // stays parked (R8)
        {4'b0100, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0000},  // gap (R7)
        {4'b0100, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0100},
        {4'b0101, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0000},  // host preempts (R6)
        {4'b0101, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001}   // host granted (R6)
    };

    task automatic check4(input logic [3:0] act, input logic [3:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] r, input logic [3:0] p, input logic pl,
                        input logic idle, input logic st, input logic [3:0] exp,
                        input string tag);
        req_i = r; prio_hi_i = p; park_last_i = pl; bus_idle_i = idle; frame_start_i = st;
        @(posedge clk); #2;
        check4(gnt_o, exp, tag);
        total++;
        if ($countones(gnt_o) > 1) begin
            fails++;
            $display("FAIL R2: got %b expected at most one bit", gnt_o);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; req_i = '0; frame_start_i = 1'b0; arb_off_i = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        check4(gnt_o, 4'b0000, "R1 reset grant");
        check4({3'b0, ext_req_o}, 4'b0000, "R1 reset ext_req");
        rst = 1'b0;
    endtask

    initial begin
        #2;
        do_reset();
        step(4'b1111, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001, "R1 first grant to host");

        do_reset();
        for (int i = 0; i < 12; i++) begin
            logic [14:0] v;
            v = VEC[i];
            step(v[14:11], v[10:7], v[6], v[5], v[4], v[3:0],
                 $sformatf("R3/R5/R6/R7/R8 table row %0d", i));
        end

        // R4: two high (0,1), two low (2,3), all requesting and starting
        do_reset();
        begin
            logic [3:0] seq [9] = '{4'b0001, 4'b0010, 4'b0100, 4'b0001, 4'b0010,
                                    4'b1000, 4'b0001, 4'b0010, 4'b0100};
            for (int i = 0; i < 9; i++)
                step(4'b1111, 4'b0011, 1'b0, 1'b0, 1'b1, seq[i],
                     $sformatf("R4 low slot order step %0d", i));
        end

        // R8: park on last user, then on host
        do_reset();
        step(4'b0100, 4'b1111, 1'b1, 1'b1, 1'b0, 4'b0100, "R8 grant dev2");
        step(4'b0100, 4'b1111, 1'b1, 1'b0, 1'b1, 4'b0100, "R8 sole requester keeps");
        step(4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0, 4'b0100, "R8 park on last user");
        step(4'b0000, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0000, "R8 gap toward host park");
        step(4'b0000, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001, "R8 park on host");

        // R9: disable
        arb_off_i = 1'b1; ext_gnt_i = 1'b1;
        step(4'b0001, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001, "R9 ext grant passes");
        check4({3'b0, ext_req_o}, 4'b0001, "R9 ext_req follows host");
        ext_gnt_i = 1'b0;
        step(4'b1110, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0000, "R9 no internal grants");
        check4({3'b0, ext_req_o}, 4'b0000, "R9 ext_req low");
        arb_off_i = 1'b0;
        step(4'b0001, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001, "R9 enabled again");
        check4({3'b0, ext_req_o}, 4'b0000, "R9 ext_req quiet when enabled");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule